// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words. A producer writes on one free-running clock and a consumer reads on another. The two clocks may be unrelated or may be the same net. Each port is qualified by a pair of enables, one active low and one active high. On the write port, the active-high enable also chooses between storing data and loading the two threshold registers.

The buffer reports four status flags:
- empty and almost-empty, produced in the read domain;
- full and almost-full, produced in the write domain.

The almost thresholds are the two offsets the user loads. Pointers move between the clock domains as Gray code through two-flop synchronizers. Each flag is therefore exact in its own domain and pessimistic about the far side for a few cycles.

The read data is registered. It is shown on the output only while the output-enable input is high; otherwise the bus is parked at zero and a drive strobe goes low. Depth is a power-of-two parameter from 64 to 8192.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: After reset, empty and almost-empty are 1, full and almost-full are 0, rd_data is 0, and both offsets hold 7.
- R2: A word is stored at a write-clock edge only when wr_en_n is 0 and wr_en_ld is 1. The pair wr_en_n=1 stores nothing. While the storing pair is held, one word is stored per cycle.
- R3: A word is read at a read-clock edge only when rd_en_n is 0, rd_en is 1 and empty is 0. rd_data takes that word at the same edge, and words leave in the order they were written.
- R4: A write attempted while full is 1 is dropped. The stored contents and the count are unchanged.
- R5: A read attempted while empty is 1 is dropped. rd_data keeps its previous value.
- R6: Once both domains have settled, full is 1 exactly when DEPTH words are held, and empty is 1 exactly when none are held.
- R7: almost_empty is 1 when the number of held words is at most the almost-empty offset.
- R8: almost_full is 1 when the number of free entries is at most the almost-full offset.
- R9: With wr_en_n=0 and wr_en_ld=0, wr_data is loaded into an offset register instead of the array. Successive loads alternate, almost-empty offset first and then almost-full offset.
- R10: With rd_en_n=0 and rd_en=0, rd_data takes an offset value at the read-clock edge. Successive reads alternate in the same order as loads, almost-empty offset first.
- R11: With rd_oe=0, rd_data is 0 and rd_drive is 0. Raising rd_oe again shows the retained registered word.
- R12: With unrelated write and read clocks and random concurrent traffic on both ports, every word arrives once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en_ld | input | 1 | Write enable, active high; low with wr_en_n low selects an offset load |
| wr_data | input | DW | Write word, or offset value during a load |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high; low with rd_en_n low selects an offset read |
| rd_oe | input | 1 | Output enable for rd_data |
| rd_data | output | DW | Registered read word, zero when rd_oe is low |
| rd_drive | output | 1 | High while rd_data is driven |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Held words at or below the almost-empty offset |
| full | output | 1 | DEPTH words held (write domain) |
| almost_full | output | 1 | Free entries at or below the almost-full offset |

## Verification

A directed fill writes one word at a time and lets both domains settle after each write. The four flags are then checked at every occupancy from zero to DEPTH. This separates the offset comparisons from the full and empty limits, and catches off-by-one errors at both thresholds.

Enable pairs that must not store are mixed into the fill, and a write is attempted while full. The following complete drain, checked word by word and ending in empty, shows whether any extra word was taken.

A random phase drives both ports at once on unrelated clocks, with the enables toggling independently. This exposes pointer and synchronizer errors that sequential traffic hides.

Offset loads and offset reads, repeated in pairs, check the alternation order and that an offset access never disturbs the array.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Which offset register the next load or offset read addresses.
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } off_sel_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic off_sel_e next_sel(input off_sel_e s);
    return (s == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
// Reset synchronizer: asserts asynchronously, releases on the second clock edge.
module dcf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// Two-flop synchronizer for a Gray-coded pointer.
module dcf_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d;
      s1_q <= s0_q;
    end
  end

  assign q = s1_q;
endmodule

// File: rtl/dcf_mem.sv
// Dual-port array: written on the write clock, read combinationally by address.
module dcf_mem #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
// Write domain: write pointer, full / almost-full, offset registers and loads.
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en_n,
  input  logic          wr_en_ld,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          mem_we,
  output logic          full,
  output logic          almost_full,
  output logic [DW-1:0] ae_off,
  output logic [DW-1:0] af_off
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = max_i(AW + 1, DW);
  localparam logic [DW-1:0] DEF = DW'(DEF_OFF);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d;
  logic [DW-1:0] ae_q, ae_d, af_q, af_d;
  off_sel_e      sel_q, sel_d;
  logic [AW:0]   rbin, count;
  logic [CW-1:0] free_w;
  logic          push, load;

  assign rbin   = g2b(rgray_sync);
  assign count  = wbin_q - rbin;
  assign full   = (count == (AW+1)'(DEPTH));
  assign free_w = CW'(DEPTH) - CW'(count);
  assign almost_full = (free_w <= CW'(af_q));

  assign push = !wr_en_n && wr_en_ld && !full;
  assign load = !wr_en_n && !wr_en_ld;

  always_comb begin
    wbin_d  = wbin_q;
    wgray_d = wgray_q;
    ae_d    = ae_q;
    af_d    = af_q;
    sel_d   = sel_q;
    if (push) begin
      wbin_d  = wbin_q + 1'b1;
      wgray_d = wbin_d ^ (wbin_d >> 1);
    end
    if (load) begin
      if (sel_q == SEL_AE) ae_d = wr_data;
      else                 af_d = wr_data;
      sel_d = next_sel(sel_q);
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= DEF;
      af_q    <= DEF;
      sel_q   <= SEL_AE;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ae_q    <= ae_d;
      af_q    <= af_d;
      sel_q   <= sel_d;
    end
  end

  assign wgray  = wgray_q;
  assign waddr  = wbin_q[AW-1:0];
  assign mem_we = push;
  assign ae_off = ae_q;
  assign af_off = af_q;
endmodule

// File: rtl/dcf_rd_side.sv
// Read domain: read pointer, empty / almost-empty, registered read word, offset reads.
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] ae_off,
  input  logic [DW-1:0] af_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          almost_empty,
  output logic [DW-1:0] rq
);
  localparam int CW = max_i(AW + 1, DW);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d, wbin, count;
  logic [DW-1:0] rq_q, rq_d;
  off_sel_e      sel_q, sel_d;
  logic          pop, peek;

  assign wbin         = g2b(wgray_sync);
  assign count        = wbin - rbin_q;
  assign empty        = (count == '0);
  assign almost_empty = (CW'(count) <= CW'(ae_off));

  assign pop  = !rd_en_n && rd_en && !empty;
  assign peek = !rd_en_n && !rd_en;

  always_comb begin
    rbin_d  = rbin_q;
    rgray_d = rgray_q;
    rq_d    = rq_q;
    sel_d   = sel_q;
    if (pop) begin
      rbin_d  = rbin_q + 1'b1;
      rgray_d = rbin_d ^ (rbin_d >> 1);
      rq_d    = mem_rdata;
    end
    if (peek) begin
      rq_d  = (sel_q == SEL_AE) ? ae_off : af_off;
      sel_d = next_sel(sel_q);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rq_q    <= '0;
      sel_q   <= SEL_AE;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      rq_q    <= rq_d;
      sel_q   <= sel_d;
    end
  end

  assign rgray = rgray_q;
  assign raddr = rbin_q[AW-1:0];
  assign rq    = rq_q;
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo #(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_en_ld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          rd_en,
  input  logic          rd_oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive,
  output logic          empty,
  output logic          almost_empty,
  output logic          full,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);

  logic          wrst_n_s, rrst_n_s;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          mem_we;
  logic [DW-1:0] mem_rdata, ae_off, af_off, rq;

  dcf_rst_sync u_wrst (.clk(wr_clk), .rst_n(rst_n), .rst_n_sync(wrst_n_s));
  dcf_rst_sync u_rrst (.clk(rd_clk), .rst_n(rst_n), .rst_n_sync(rrst_n_s));

  dcf_sync2 #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n_s), .d(rgray), .q(rgray_s));
  dcf_sync2 #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n_s), .d(wgray), .q(wgray_s));

  dcf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_wr_side #(.AW(AW), .DW(DW), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk(wr_clk), .wrst_n(wrst_n_s), .wr_en_n(wr_en_n), .wr_en_ld(wr_en_ld),
    .wr_data(wr_data), .rgray_sync(rgray_s), .wgray(wgray), .waddr(waddr),
    .mem_we(mem_we), .full(full), .almost_full(almost_full),
    .ae_off(ae_off), .af_off(af_off)
  );

  dcf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rd_clk), .rrst_n(rrst_n_s), .rd_en_n(rd_en_n), .rd_en(rd_en),
    .wgray_sync(wgray_s), .mem_rdata(mem_rdata), .ae_off(ae_off), .af_off(af_off),
    .rgray(rgray), .raddr(raddr), .empty(empty), .almost_empty(almost_empty),
    .rq(rq)
  );

  assign rd_data  = rd_oe ? rq : '0;
  assign rd_drive = rd_oe;
endmodule

// File: rtl/dcf_pflag_fifo_chk.sv
module dcf_pflag_fifo_chk #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en_n,
  input logic          wr_en_ld,
  input logic          rd_en_n,
  input logic          rd_en,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] rq
);
  p_wgray_step_r2: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray)));

  p_no_store_idle_r2: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en_n || !wr_en_ld) |=> $stable(wgray));

  p_rgray_step_r3: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $onehot0(rgray ^ $past(rgray)));

  p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (full && !wr_en_n && wr_en_ld) |=> $stable(wgray));

  p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (empty && !rd_en_n && rd_en) |=> ($stable(rgray) && $stable(rq)));

  p_empty_in_ae_r7: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    empty |-> almost_empty);

  p_full_in_af_r8: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    full |-> almost_full);
endmodule

bind dcf_pflag_fifo dcf_pflag_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n_s), .rrst_n(rrst_n_s),
  .wr_en_n(wr_en_n), .wr_en_ld(wr_en_ld), .rd_en_n(rd_en_n), .rd_en(rd_en),
  .full(full), .almost_full(almost_full), .empty(empty),
  .almost_empty(almost_empty), .wgray(wgray), .rgray(rgray), .rq(rq)
);

// File: tb/dcf_pflag_fifo_tb.sv
`timescale 1ns/1ps
module dcf_pflag_fifo_tb;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_en_ld = 1'b0, rd_en_n = 1'b1, rd_en = 1'b0, rd_oe = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive, empty, almost_empty, full, almost_full;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd;
  int ae_set = 7, af_set = 7;
  bit wr_done = 0;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.6 rd_clk = ~rd_clk;   // unrelated read clock

  dcf_pflag_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_en_ld(wr_en_ld), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_en(rd_en), .rd_oe(rd_oe),
    .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty),
    .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ae(input int n); return n <= ae_set; endfunction
  function automatic bit exp_af(input int n); return (DEPTH - n) <= af_set; endfunction

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic check_flags(input int n);
    check(empty == (n == 0), "R6 empty", empty, n == 0);
    check(full == (n == DEPTH), "R6 full", full, n == DEPTH);
    check(almost_empty == exp_ae(n), "R7 almost_empty", almost_empty, exp_ae(n));
    check(almost_full == exp_af(n), "R8 almost_full", almost_full, exp_af(n));
  endtask

  task automatic wr_pins(input logic en_n, input logic en_hi, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = en_n; wr_en_ld = en_hi; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1; wr_en_ld = 1'b0;
  endtask

  task automatic push_one(input logic [DW-1:0] d);
    wr_pins(1'b0, 1'b1, d);
    exp_q.push_back(d);
  endtask

  // Read with the given pins; returns rd_data one read-clock edge later.
  task automatic rd_pins(input logic en_n, input logic en_hi, output logic [DW-1:0] v);
    @(negedge rd_clk);
    rd_en_n = en_n; rd_en = en_hi;
    @(negedge rd_clk);
    v = rd_data;
    rd_en_n = 1'b1; rd_en = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] v, e;
    void'($urandom(32'd4711));

    repeat (10) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(almost_empty == 1'b1, "R1 almost_empty", almost_empty, 1);
    check(full == 1'b0, "R1 full", full, 0);
    check(almost_full == 1'b0, "R1 almost_full", almost_full, 0);
    check(rd_data == '0, "R1 rd_data", rd_data, 0);
    // R10 default offsets read back in order
    rd_pins(1'b0, 1'b0, v); check(v == 9'd7, "R1 R10 ae default", v, 7);
    rd_pins(1'b0, 1'b0, v); check(v == 9'd7, "R1 R10 af default", v, 7);

    // R9 load order: almost-empty first, then almost-full
    wr_pins(1'b0, 1'b0, 9'd3);
    wr_pins(1'b0, 1'b0, 9'd4);
    ae_set = 3; af_set = 4;
    settle();
    rd_pins(1'b0, 1'b0, v); check(v == 9'd3, "R9 R10 ae loaded", v, 3);
    rd_pins(1'b0, 1'b0, v); check(v == 9'd4, "R9 R10 af loaded", v, 4);
    check(empty == 1'b1, "R9 load not stored", empty, 1);

    // Fill one word at a time, flags at every level (R6 R7 R8)
    check_flags(0);
    for (int n = 1; n <= DEPTH; n++) begin
      if (n == 10) begin
        wr_pins(1'b1, 1'b1, 9'h1F0);  // R2 non-storing pairs
        wr_pins(1'b1, 1'b0, 9'h1F1);
      end
      push_one(9'($urandom));
      settle();
      check_flags(n);
    end

    // R4 write while full dropped
    wr_pins(1'b0, 1'b1, 9'h155);
    settle();
    check(full == 1'b1, "R4 still full", full, 1);

    // Drain with order check (R3), then empty proves nothing extra (R2 R4)
    for (int i = 0; i < DEPTH; i++) begin
      e = exp_q.pop_front();
      rd_pins(1'b0, 1'b1, v);
      check(v == e, "R3 drain order", v, e);
      last_rd = v;
    end
    settle();
    check(empty == 1'b1, "R4 R6 empty after drain", empty, 1);
    check_flags(0);

    // R5 read while empty keeps rd_data
    rd_pins(1'b0, 1'b1, v);
    check(v == last_rd, "R5 read while empty", v, last_rd);

    // R2 burst: held enables store one word per cycle
    @(negedge wr_clk);
    for (int i = 0; i < 5; i++) begin
      wr_en_n = 1'b0; wr_en_ld = 1'b1; wr_data = 9'(9'h40 + i);
      exp_q.push_back(9'(9'h40 + i));
      @(negedge wr_clk);
    end
    wr_en_n = 1'b1; wr_en_ld = 1'b0;
    settle();
    check_flags(5);
    for (int i = 0; i < 5; i++) begin
      e = exp_q.pop_front();
      rd_pins(1'b0, 1'b1, v);
      check(v == e, "R2 R3 burst word", v, e);
      last_rd = v;
    end

    // R11 output enable
    @(negedge rd_clk); rd_oe = 1'b0;
    @(negedge rd_clk);
    check(rd_data == '0, "R11 rd_data parked", rd_data, 0);
    check(rd_drive == 1'b0, "R11 rd_drive low", rd_drive, 0);
    rd_oe = 1'b1;
    @(negedge rd_clk);
    check(rd_data == last_rd, "R11 retained word", rd_data, last_rd);
    check(rd_drive == 1'b1, "R11 rd_drive high", rd_drive, 1);

    // R12 random concurrent traffic on unrelated clocks
    fork
      begin
        for (int c = 0; c < 3000; c++) begin
          int r;
          logic [DW-1:0] d;
          @(negedge wr_clk);
          r = int'($urandom % 10);
          d = 9'($urandom);
          wr_data = d;
          if (r < 6) begin
            wr_en_n = 1'b0; wr_en_ld = 1'b1;
            if (!full) exp_q.push_back(d);
          end else if (r < 8) begin
            wr_en_n = 1'b1; wr_en_ld = 1'b1;
          end else begin
            wr_en_n = 1'b1; wr_en_ld = 1'b0;
          end
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1; wr_en_ld = 1'b0;
        wr_done = 1;
      end
      begin
        bit pend = 0;
        logic [DW-1:0] pe = '0;
        while (!(wr_done && exp_q.size() == 0 && !pend)) begin
          @(negedge rd_clk);
          if (pend) begin
            check(rd_data == pe, "R12 random order", rd_data, pe);
            pend = 0;
          end
          if (($urandom % 10) < 5) begin
            rd_en_n = 1'b0; rd_en = 1'b1;
            if (!empty) begin
              pend = 1;
              pe = exp_q.pop_front();
            end
          end else begin
            rd_en_n = 1'b1; rd_en = 1'b0;
          end
        end
        rd_en_n = 1'b1; rd_en = 1'b0;
      end
    join
    settle();
    check(empty == 1'b1, "R12 empty at end", empty, 1);
    rd_pins(1'b0, 1'b0, v); check(v == 9'd3, "R10 ae kept", v, 3);
    rd_pins(1'b0, 1'b0, v); check(v == 9'd4, "R10 af kept", v, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule